// File: doc/BRIEF.md
# Per-Core Interrupt Claim Interface

This block is the interrupt front end that sits beside one processor core. It gathers three families of interrupt sources into a single ID space: sixteen software interrupts (IDs 0 to 15) raised by peer cores, sixteen private interrupts wired only to this core (IDs 16 to 31), and the common interrupts already routed to this core (IDs 32 and up). Each ID has its own enable bit. The block raises one request line to the core whenever an enabled, unclaimed interrupt is waiting.

Software sees a small register window. Writing an ID to the set-enable or clear-enable register turns that ID on or off. Reading the claim register returns the ID to service and marks it as in service. Writing the same ID to the completion register retires it. A separate status register exposes the best waiting ID, with a more-pending flag in bit 31, and reading it changes nothing. A handler can therefore claim, service and complete in a loop until the flag reads zero. Writing the doorbell register sends a software interrupt to a set of cores through an outgoing request bus.

Top module: `ictl_top`

## Requirements
- R1: After reset every enable bit, in-service bit and software pending bit is clear, the interface enable (bit 0 of the register at 0x000) reads 0, `irqOut` is low and `swReqValid` is low.
- R2: A write of an ID in bits [9:0] to 0x0A0 enables that ID, and a write to 0x0A4 disables it. IDs at or above `NUM_IDS` are ignored.
- R3: `irqOut` is high exactly when bit 0 of the control register is 1 and at least one enabled ID that is not in service is pending.
- R4: When several IDs qualify, the lowest ID wins. A read of 0x06C returns it in bits [9:0], with bits [31:10] zero, and marks it in service.
- R5: An ID in service is not reported or claimed again until its ID is written to 0x0B4. That write has no effect on an ID that is not in service.
- R6: A read of 0x06C with no qualifying ID, or with the interface disabled, returns 0x3FF and marks nothing in service.
- R7: A read of 0x068 returns bit 31 set when an ID qualifies and bits [9:0] holding the winning ID (0x3FF if none). It claims nothing.
- R8: A write to 0x060 drives `swReqValid` high for exactly the next cycle. During that cycle `swReqId` holds write bits [3:0] and `swReqMask` holds write bits [8+NUM_CORES-1:8].
- R9: A pulse on `swSetIn[k]` makes software ID k pending. It stays pending until it is claimed. Private IDs 16 to 31 and common IDs 32 and up follow their input levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a claim takes effect at the clock edge |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the same cycle as `regRdEn` |
| privIrq | input | 16 | Private interrupt levels, IDs 16 to 31 |
| commonIrq | input | NUM_IDS-32 | Routed common interrupt levels, IDs 32 and up |
| swSetIn | input | 16 | Incoming software interrupt pulses, IDs 0 to 15 |
| irqOut | output | 1 | Interrupt request to the core |
| swReqValid | output | 1 | Outgoing software interrupt request valid |
| swReqMask | output | NUM_CORES | Target core mask |
| swReqId | output | 4 | Software interrupt ID to raise on the targets |

## Verification
Pending patterns mix one source from each family (a software, a private and a common ID) so that a claim sequence shows whether the winner is picked by ID order rather than by source type. The sequence must come back as the ascending IDs and then the empty code. A lone private level, toggled against its enable bit and against the interface enable, separates the gating terms of the request line. Completing a software ID after its claim, and completing a private ID whose level is still high, separate the clear-on-claim behaviour of software sources from the re-report of level sources. Doorbell writes with different masks and IDs confirm the field positions and the one-cycle pulse.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int ID_FIELD = 10;
  localparam logic [ID_FIELD-1:0] NO_ID = '1;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_SIG   = 12'h060;
  localparam logic [11:0] OFS_HP    = 12'h068;
  localparam logic [11:0] OFS_READY = 12'h06C;
  localparam logic [11:0] OFS_SETEN = 12'h0A0;
  localparam logic [11:0] OFS_CLREN = 12'h0A4;
  localparam logic [11:0] OFS_ACK   = 12'h0B4;

  typedef struct packed {
    logic ctrlWr;
    logic ctrlRd;
    logic sigWr;
    logic setEn;
    logic clrEn;
    logic ack;
    logic readyRd;
    logic hpRd;
  } strobes_t;
endpackage

// File: rtl/ictl_ctrl.sv
module ictl_ctrl
  import ictl_pkg::*;
(
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [11:0] regAddr,
  output strobes_t    st
);
  always_comb begin
    st         = '0;
    st.ctrlWr  = regWrEn && (regAddr == OFS_CTRL);
    st.sigWr   = regWrEn && (regAddr == OFS_SIG);
    st.setEn   = regWrEn && (regAddr == OFS_SETEN);
    st.clrEn   = regWrEn && (regAddr == OFS_CLREN);
    st.ack     = regWrEn && (regAddr == OFS_ACK);
    st.ctrlRd  = regRdEn && (regAddr == OFS_CTRL);
    st.readyRd = regRdEn && (regAddr == OFS_READY);
    st.hpRd    = regRdEn && (regAddr == OFS_HP);
  end
endmodule

// File: rtl/ictl_datapath.sv
module ictl_datapath
  import ictl_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int NUM_CORES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               st,
  input  logic [31:0]            wrData,
  input  logic [15:0]            privIrq,
  input  logic [NUM_IDS-33:0]    commonIrq,
  input  logic [15:0]            swSetIn,
  output logic [31:0]            rdData,
  output logic                   irqOut,
  output logic                   swReqValid,
  output logic [NUM_CORES-1:0]   swReqMask,
  output logic [3:0]             swReqId
);
  localparam int IDW = $clog2(NUM_IDS);

  logic               ctrlEnQ;
  logic [NUM_IDS-1:0] enQ, activeQ, pendVec, candVec;
  logic [15:0]        swPendQ, swPendNext;
  logic [ID_FIELD-1:0] bestId, wrId;
  logic [IDW-1:0]     bestIdx, wrIdx;
  logic               hasAny, hasCand, claim, wrIdOk;

  assign pendVec = {commonIrq, privIrq, swPendQ};
  assign candVec = pendVec & enQ & ~activeQ;

  always_comb begin
    bestId = NO_ID;
    hasAny = 1'b0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (candVec[i]) begin
        bestId = ID_FIELD'(i);
        hasAny = 1'b1;
      end
    end
  end

  assign bestIdx = bestId[IDW-1:0];
  assign hasCand = ctrlEnQ && hasAny;
  assign irqOut  = hasCand;
  assign claim   = st.readyRd && hasCand;
  assign wrId    = wrData[ID_FIELD-1:0];
  assign wrIdx   = wrId[IDW-1:0];
  assign wrIdOk  = wrId < ID_FIELD'(NUM_IDS);

  always_comb begin
    swPendNext = swPendQ;
    if (claim && bestId < ID_FIELD'(16)) swPendNext[bestIdx[3:0]] = 1'b0;
    swPendNext = swPendNext | swSetIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEnQ    <= 1'b0;
      enQ        <= '0;
      activeQ    <= '0;
      swPendQ    <= '0;
      swReqValid <= 1'b0;
      swReqMask  <= '0;
      swReqId    <= '0;
    end else begin
      if (st.ctrlWr) ctrlEnQ <= wrData[0];
      if (st.setEn && wrIdOk) enQ[wrIdx] <= 1'b1;
      if (st.clrEn && wrIdOk) enQ[wrIdx] <= 1'b0;
      if (st.ack && wrIdOk) activeQ[wrIdx] <= 1'b0;
      if (claim) activeQ[bestIdx] <= 1'b1;
      swPendQ    <= swPendNext;
      swReqValid <= st.sigWr;
      if (st.sigWr) begin
        swReqMask <= wrData[8 +: NUM_CORES];
        swReqId   <= wrData[3:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (st.ctrlRd)  rdData = {31'b0, ctrlEnQ};
    if (st.hpRd)    rdData = {hasCand, 21'b0, hasCand ? bestId : NO_ID};
    if (st.readyRd) rdData = {22'b0, hasCand ? bestId : NO_ID};
  end

  p_claim_marks_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    claim |=> activeQ[$past(bestIdx)]);
  p_claim_is_enabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> (enQ[bestIdx] && pendVec[bestIdx] && !activeQ[bestIdx]));
  p_empty_read_no_claim_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.readyRd && !hasCand && !st.ack) |=> $stable(activeQ));
  p_sw_cleared_on_claim_r9: assert property (@(posedge clk) disable iff (!rstN)
    (claim && bestId < ID_FIELD'(16) && !swSetIn[bestIdx[3:0]]) |=> !swPendQ[$past(bestIdx[3:0])]);
  p_sig_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.sigWr |=> swReqValid);
  p_sig_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    !st.sigWr |=> !swReqValid);
  p_irq_off_when_disabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.ctrlWr && !wrData[0]) |=> !irqOut);
endmodule

// File: rtl/ictl_top.sv
module ictl_top
  import ictl_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [11:0]          regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [15:0]          privIrq,
  input  logic [NUM_IDS-33:0]  commonIrq,
  input  logic [15:0]          swSetIn,
  output logic                 irqOut,
  output logic                 swReqValid,
  output logic [NUM_CORES-1:0] swReqMask,
  output logic [3:0]           swReqId
);
  strobes_t st;

  ictl_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .st      (st)
  );

  ictl_datapath #(.NUM_IDS(NUM_IDS), .NUM_CORES(NUM_CORES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .wrData     (regWrData),
    .privIrq    (privIrq),
    .commonIrq  (commonIrq),
    .swSetIn    (swSetIn),
    .rdData     (regRdData),
    .irqOut     (irqOut),
    .swReqValid (swReqValid),
    .swReqMask  (swReqMask),
    .swReqId    (swReqId)
  );
endmodule

// File: tb/ictl_top_tb.sv
module ictl_top_tb;
  localparam int NUM_IDS = 64;
  localparam int NUM_CORES = 4;

  logic clk = 0, rstN = 0, regWrEn = 0, regRdEn = 0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [15:0] privIrq = '0, swSetIn = '0;
  logic [NUM_IDS-33:0] commonIrq = '0;
  logic irqOut, swReqValid;
  logic [NUM_CORES-1:0] swReqMask;
  logic [3:0] swReqId;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ictl_top #(.NUM_IDS(NUM_IDS), .NUM_CORES(NUM_CORES)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1 regWrEn = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a;
    #1 d = regRdData;
    @(posedge clk); #1 regRdEn = 0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 irqOut", irqOut, 0);
    check("R1 swReqValid", swReqValid, 0);
    rd(12'h000, d); check("R1 ctrl", d, 0);
    rd(12'h06C, d); check("R1 ready empty", d, 32'h3FF);
  endtask

  task automatic testGating();
    logic [31:0] d;
    wr(12'h000, 1);
    privIrq[4] = 1;
    #1 check("R3 not enabled", irqOut, 0);
    wr(12'h0A0, 20);
    check("R2 R3 enabled irq", irqOut, 1);
    rd(12'h068, d); check("R7 hp", d, 32'h8000_0014);
    wr(12'h000, 0);
    check("R3 iface off", irqOut, 0);
    rd(12'h06C, d); check("R6 disabled ready", d, 32'h3FF);
    wr(12'h000, 1);
    check("R6 nothing claimed", irqOut, 1);
    wr(12'h0A4, 20);
    check("R2 clear enable", irqOut, 0);
    wr(12'h0A0, 100);
    rd(12'h068, d); check("R2 out of range ignored", d, 32'h3FF);
    privIrq[4] = 0;
  endtask

  task automatic testPriority();
    logic [31:0] d;
    privIrq[4] = 1; commonIrq[8] = 1;
    @(negedge clk); swSetIn[3] = 1; @(negedge clk); swSetIn[3] = 0;
    wr(12'h0A0, 40); wr(12'h0A0, 20); wr(12'h0A0, 3);
    rd(12'h068, d); check("R7 hp lowest", d, 32'h8000_0003);
    rd(12'h068, d); check("R7 hp no claim", d, 32'h8000_0003);
    rd(12'h06C, d); check("R4 claim sw3", d, 3);
    rd(12'h06C, d); check("R4 claim priv20", d, 20);
    rd(12'h068, d); check("R7 one left", d, 32'h8000_0028);
    rd(12'h06C, d); check("R4 claim common40", d, 40);
    check("R5 all in service", irqOut, 0);
    rd(12'h06C, d); check("R6 empty", d, 32'h3FF);
    wr(12'h0B4, 3);
    check("R9 sw cleared by claim", irqOut, 0);
    wr(12'h0B4, 20);
    rd(12'h068, d); check("R5 level re-reported", d, 32'h8000_0014);
    wr(12'h0B4, 7);
    rd(12'h06C, d); check("R5 reclaim 20", d, 20);
    privIrq[4] = 0; commonIrq[8] = 0;
    wr(12'h0B4, 20); wr(12'h0B4, 40);
    check("R9 levels dropped", irqOut, 0);
  endtask

  task automatic testSignal();
    wr(12'h060, 32'h0000_0A05);
    check("R8 valid", swReqValid, 1);
    check("R8 mask", swReqMask, 4'hA);
    check("R8 id", swReqId, 5);
    @(posedge clk); #1 check("R8 one cycle", swReqValid, 0);
    wr(12'h060, 32'h0000_030C);
    check("R8 mask2", swReqMask, 4'h3);
    check("R8 id2", swReqId, 4'hC);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testGating();
    testPriority();
    testSignal();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule